// File: doc/BRIEF.md
# Pulse Programming Sequencer

This block burns an image into a byte-wide one-time-programmable or erasable memory, one byte at a time, using a fast pulse algorithm. It fetches each source byte from a small image memory port. It drives the target's address, its data bus together with a drive enable, its active-low chip-enable and output-enable, and two supply-select outputs. The supply selects choose either the elevated programming levels or the nominal read level. The target's read-back bus is sampled and compared against the image.

A run has three phases. First, a blind pass gives every location exactly one program pulse. Second, an interactive pass reads each byte back under elevated supplies and re-pulses a mismatching byte, with a cap on the number of extra pulses per byte. Third, a closing pass drops both supplies to nominal and compares every byte once more. The run ends with done raised and exactly one of pass or fail set. On a failure, the failing location is reported. All waits are counted in clock cycles set by parameters: pulse width, setup, data hold and read-sample delay.

Top module: `burn_sequencer`

## Requirements
- R1: While reset is high and in the cycle after it, the block is parked: chip-enable and output-enable high (1), both supply selects low (0), data drive off, and done, pass and fail all 0.
- R2: Every program pulse is preceded by at least SETUP_CYC cycles in which both supply selects are continuously high (1).
- R3: A program pulse is a window with chip-enable low (0) and output-enable high (1). It lasts exactly PULSE_CYC cycles, with both supply selects high, the data drive on, and the data bus equal to the image byte at the current address. The blind pass gives each address, from 0 to the last, exactly one pulse.
- R4: Address, data and data drive are unchanged for at least SETUP_CYC cycles before a pulse starts. They remain unchanged for at least HOLD_CYC cycles after it ends.
- R5: An interactive read-back has chip-enable high, output-enable low, data drive off and both supplies high. Each read window at one address lasts at least SAMPLE_CYC cycles before the comparison.
- R6: In the interactive pass, a mismatching byte gets one more pulse and is read again. At most MAX_TRIES extra pulses are given per address, and the count restarts at each new address. A byte still wrong after MAX_TRIES extra pulses ends the run with fail, and fail_addr_o holds that address.
- R7: After every address has verified, both supply selects go low. Each address from 0 upward is read with chip-enable and output-enable both low, with no data drive. The first mismatch ends the run with fail at that address.
- R8: When done_o is 1, exactly one of pass_o and fail_o is 1. While done_o is 0, both are 0. The result is held until the next start.
- R9: start_i is only honoured when the block is idle or done. It then clears done, pass and fail within one cycle and restarts at address 0. A start during a run has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a programming run |
| img_addr_o | output | AW | Image memory read address |
| img_data_i | input | DW | Image byte at img_addr_o (combinational read) |
| mem_addr_o | output | AW | Target memory address |
| mem_data_o | output | DW | Data presented to the target |
| mem_drive_o | output | 1 | Data bus drive enable toward the target |
| mem_ce_n_o | output | 1 | Target chip-enable, active low |
| mem_oe_n_o | output | 1 | Target output-enable, active low |
| vpp_hi_o | output | 1 | Programming supply select: 1 elevated, 0 nominal |
| vcc_hi_o | output | 1 | Core supply select: 1 elevated, 0 nominal |
| mem_data_i | input | DW | Read-back data from the target |
| done_o | output | 1 | Run finished |
| pass_o | output | 1 | Run finished with every byte correct |
| fail_o | output | 1 | Run finished with a failing byte |
| fail_addr_o | output | AW | Address of the failing byte |

## Verification
Pulse, setup, hold and read-window timing are due relative to one another rather than at fixed cycles from start. A monitor samples every port on the falling clock edge. It measures, in samples, how long address and data stood still before a pulse, how long the pulse lasted and how long data held afterwards, and compares each span with the parameter. The pass/fail result and the failing address are due only when done rises, so the bench waits for done and reads them on the next falling edge. Pulse counts per address and the number of nominal-supply reads are compared with counts derived from how many pulses each byte of the model needs to stick.

// File: rtl/burn_pkg.sv
package burn_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_RAMP,
        S_PSET,
        S_PULSE,
        S_PHOLD,
        S_VREAD,
        S_NOM,
        S_FREAD,
        S_DONE
    } seq_state_e;

    typedef enum logic [1:0] {
        PH_BLIND,
        PH_RETRY,
        PH_FINAL
    } phase_e;

    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic drive;
        logic vpp_hi;
        logic vcc_hi;
    } pins_t;

    localparam pins_t PINS_PARK = '{ce_n: 1'b1, oe_n: 1'b1, drive: 1'b0,
                                    vpp_hi: 1'b0, vcc_hi: 1'b0};

    // Pin levels seen by the target in each sequencer state.
    function automatic pins_t pins_for(seq_state_e s);
        pins_t p;
        p = PINS_PARK;
        case (s)
            S_RAMP: begin
                p.vpp_hi = 1'b1;
                p.vcc_hi = 1'b1;
            end
            S_PSET, S_PHOLD: begin
                p.vpp_hi = 1'b1;
                p.vcc_hi = 1'b1;
                p.drive  = 1'b1;
            end
            S_PULSE: begin
                p.vpp_hi = 1'b1;
                p.vcc_hi = 1'b1;
                p.drive  = 1'b1;
                p.ce_n   = 1'b0;
            end
            S_VREAD: begin
                p.vpp_hi = 1'b1;
                p.vcc_hi = 1'b1;
                p.oe_n   = 1'b0;
            end
            S_FREAD: begin
                p.ce_n = 1'b0;
                p.oe_n = 1'b0;
            end
            default: p = PINS_PARK;
        endcase
        return p;
    endfunction

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction

endpackage

// File: rtl/burn_timer.sv
module burn_timer #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            cnt_q <= '0;
        end else if (cnt_q != '1) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/burn_walker.sv
module burn_walker #(
    parameter int AW        = 4,
    parameter int MAX_TRIES = 10,
    parameter int TW        = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          addr_clr_i,
    input  logic          addr_inc_i,
    input  logic          try_clr_i,
    input  logic          try_inc_i,
    output logic [AW-1:0] addr_o,
    output logic          last_o,
    output logic [TW-1:0] tries_o,
    output logic          tries_max_o
);
    logic [AW-1:0] addr_q;
    logic [TW-1:0] tries_q;

    always_ff @(posedge clk) begin
        if (rst || addr_clr_i) begin
            addr_q <= '0;
        end else if (addr_inc_i) begin
            addr_q <= addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || try_clr_i) begin
            tries_q <= '0;
        end else if (try_inc_i) begin
            tries_q <= tries_q + 1'b1;
        end
    end

    assign addr_o      = addr_q;
    assign last_o      = &addr_q;
    assign tries_o     = tries_q;
    assign tries_max_o = (tries_q == TW'(MAX_TRIES));

    // R6: the extra-pulse count never passes its cap
    assert_tries_cap_R6: assert property (@(posedge clk) disable iff (rst)
        tries_q <= TW'(MAX_TRIES));

    // R6: no extra pulse is requested once the cap is reached
    assert_no_inc_at_cap_R6: assert property (@(posedge clk) disable iff (rst)
        try_inc_i |-> !tries_max_o);
endmodule

// File: rtl/burn_ctrl.sv
module burn_ctrl
    import burn_pkg::*;
#(
    parameter int AW         = 4,
    parameter int DW         = 8,
    parameter int PULSE_CYC  = 20,
    parameter int SETUP_CYC  = 3,
    parameter int HOLD_CYC   = 3,
    parameter int SAMPLE_CYC = 4,
    parameter int CW         = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [CW-1:0] tmr_i,
    input  logic [DW-1:0] rd_data_i,
    input  logic [DW-1:0] exp_data_i,
    input  logic          addr_last_i,
    input  logic          tries_max_i,
    input  logic [AW-1:0] addr_i,
    output logic          tmr_clr_o,
    output logic          addr_clr_o,
    output logic          addr_inc_o,
    output logic          try_clr_o,
    output logic          try_inc_o,
    output pins_t         pins_o,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o
);
    seq_state_e    st_q, st_n;
    phase_e        ph_q, ph_n;
    logic          pass_q, fail_q;
    logic [AW-1:0] fa_q;
    logic [CW-1:0] need_m1;
    logic          step, match;
    logic          wipe, set_pass, set_fail;

    // Length of each timed state, less one (the timer starts at zero).
    always_comb begin
        case (st_q)
            S_RAMP, S_PSET, S_NOM: need_m1 = CW'(SETUP_CYC - 1);
            S_PULSE:               need_m1 = CW'(PULSE_CYC - 1);
            S_PHOLD:               need_m1 = CW'(HOLD_CYC - 1);
            S_VREAD, S_FREAD:      need_m1 = CW'(SAMPLE_CYC - 1);
            default:               need_m1 = '0;
        endcase
    end

    assign step  = (tmr_i == need_m1);
    assign match = (rd_data_i == exp_data_i);

    always_comb begin
        st_n       = st_q;
        ph_n       = ph_q;
        tmr_clr_o  = 1'b0;
        addr_clr_o = 1'b0;
        addr_inc_o = 1'b0;
        try_clr_o  = 1'b0;
        try_inc_o  = 1'b0;
        wipe       = 1'b0;
        set_pass   = 1'b0;
        set_fail   = 1'b0;
        case (st_q)
            S_IDLE, S_DONE: begin
                if (start_i) begin
                    st_n       = S_RAMP;
                    ph_n       = PH_BLIND;
                    tmr_clr_o  = 1'b1;
                    addr_clr_o = 1'b1;
                    try_clr_o  = 1'b1;
                    wipe       = 1'b1;
                end
            end
            S_RAMP: begin
                if (step) begin
                    st_n      = S_PSET;
                    tmr_clr_o = 1'b1;
                end
            end
            S_PSET: begin
                if (step) begin
                    st_n      = S_PULSE;
                    tmr_clr_o = 1'b1;
                end
            end
            S_PULSE: begin
                if (step) begin
                    st_n      = S_PHOLD;
                    tmr_clr_o = 1'b1;
                end
            end
            S_PHOLD: begin
                if (step) begin
                    tmr_clr_o = 1'b1;
                    if (ph_q == PH_BLIND) begin
                        if (addr_last_i) begin
                            st_n       = S_VREAD;
                            ph_n       = PH_RETRY;
                            addr_clr_o = 1'b1;
                            try_clr_o  = 1'b1;
                        end else begin
                            st_n       = S_PSET;
                            addr_inc_o = 1'b1;
                        end
                    end else begin
                        st_n = S_VREAD;
                    end
                end
            end
            S_VREAD: begin
                if (step) begin
                    tmr_clr_o = 1'b1;
                    if (match) begin
                        try_clr_o = 1'b1;
                        if (addr_last_i) begin
                            st_n       = S_NOM;
                            ph_n       = PH_FINAL;
                            addr_clr_o = 1'b1;
                        end else begin
                            addr_inc_o = 1'b1;
                        end
                    end else if (tries_max_i) begin
                        st_n     = S_DONE;
                        set_fail = 1'b1;
                    end else begin
                        st_n      = S_PSET;
                        try_inc_o = 1'b1;
                    end
                end
            end
            S_NOM: begin
                if (step) begin
                    st_n      = S_FREAD;
                    tmr_clr_o = 1'b1;
                end
            end
            S_FREAD: begin
                if (step) begin
                    tmr_clr_o = 1'b1;
                    if (!match) begin
                        st_n     = S_DONE;
                        set_fail = 1'b1;
                    end else if (addr_last_i) begin
                        st_n     = S_DONE;
                        set_pass = 1'b1;
                    end else begin
                        addr_inc_o = 1'b1;
                    end
                end
            end
            default: begin
                st_n = S_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q   <= S_IDLE;
            ph_q   <= PH_BLIND;
            pass_q <= 1'b0;
            fail_q <= 1'b0;
            fa_q   <= '0;
        end else begin
            st_q <= st_n;
            ph_q <= ph_n;
            if (wipe) begin
                pass_q <= 1'b0;
                fail_q <= 1'b0;
            end
            if (set_pass) pass_q <= 1'b1;
            if (set_fail) begin
                fail_q <= 1'b1;
                fa_q   <= addr_i;
            end
        end
    end

    assign pins_o      = pins_for(st_q);
    assign done_o      = (st_q == S_DONE);
    assign pass_o      = pass_q;
    assign fail_o      = fail_q;
    assign fail_addr_o = fa_q;

    // R8: a finished run carries exactly one verdict
    assert_done_verdict_R8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> ($countones({pass_o, fail_o}) == 1));

    // R8: no verdict is visible while a run is pending
    assert_no_early_verdict_R8: assert property (@(posedge clk) disable iff (rst)
        !done_o |-> (!pass_o && !fail_o));

    // R9: an accepted start clears the verdict one cycle later
    assert_start_clears_R9: assert property (@(posedge clk) disable iff (rst)
        (start_i && (done_o || st_q == S_IDLE)) |=> (!done_o && !pass_o && !fail_o));
endmodule

// File: rtl/burn_sequencer.sv
module burn_sequencer
    import burn_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int PULSE_CYC  = 5000,
    parameter int SETUP_CYC  = 110,
    parameter int HOLD_CYC   = 110,
    parameter int SAMPLE_CYC = 8,
    parameter int MAX_TRIES  = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    output logic [AW-1:0] img_addr_o,
    input  logic [DW-1:0] img_data_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_data_o,
    output logic          mem_drive_o,
    output logic          mem_ce_n_o,
    output logic          mem_oe_n_o,
    output logic          vpp_hi_o,
    output logic          vcc_hi_o,
    input  logic [DW-1:0] mem_data_i,
    output logic          done_o,
    output logic          pass_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o
);
    localparam int unsigned LONGEST = max4(PULSE_CYC, SETUP_CYC, HOLD_CYC, SAMPLE_CYC);
    localparam int CW = $clog2(LONGEST + 2);
    localparam int TW = $clog2(MAX_TRIES + 2);

    logic [CW-1:0] tmr;
    logic          tmr_clr, addr_clr, addr_inc, try_clr, try_inc;
    logic [AW-1:0] addr;
    logic          last, tries_max;
    logic [TW-1:0] tries;
    pins_t         pins;

    burn_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr_i (tmr_clr),
        .cnt_o (tmr)
    );

    burn_walker #(.AW(AW), .MAX_TRIES(MAX_TRIES), .TW(TW)) u_walker (
        .clk         (clk),
        .rst         (rst),
        .addr_clr_i  (addr_clr),
        .addr_inc_i  (addr_inc),
        .try_clr_i   (try_clr),
        .try_inc_i   (try_inc),
        .addr_o      (addr),
        .last_o      (last),
        .tries_o     (tries),
        .tries_max_o (tries_max)
    );

    burn_ctrl #(
        .AW(AW), .DW(DW), .PULSE_CYC(PULSE_CYC), .SETUP_CYC(SETUP_CYC),
        .HOLD_CYC(HOLD_CYC), .SAMPLE_CYC(SAMPLE_CYC), .CW(CW)
    ) u_ctrl (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start_i),
        .tmr_i       (tmr),
        .rd_data_i   (mem_data_i),
        .exp_data_i  (img_data_i),
        .addr_last_i (last),
        .tries_max_i (tries_max),
        .addr_i      (addr),
        .tmr_clr_o   (tmr_clr),
        .addr_clr_o  (addr_clr),
        .addr_inc_o  (addr_inc),
        .try_clr_o   (try_clr),
        .try_inc_o   (try_inc),
        .pins_o      (pins),
        .done_o      (done_o),
        .pass_o      (pass_o),
        .fail_o      (fail_o),
        .fail_addr_o (fail_addr_o)
    );

    assign img_addr_o  = addr;
    assign mem_addr_o  = addr;
    assign mem_data_o  = img_data_i;
    assign mem_drive_o = pins.drive;
    assign mem_ce_n_o  = pins.ce_n;
    assign mem_oe_n_o  = pins.oe_n;
    assign vpp_hi_o    = pins.vpp_hi;
    assign vcc_hi_o    = pins.vcc_hi;

    // Checker state: pulse length and how long the bus has stood still.
    logic          pulse;
    logic [CW-1:0] pulse_len;
    logic [CW-1:0] still_len;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] prev_data;
    logic          prev_drive;

    assign pulse = !mem_ce_n_o && mem_oe_n_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            pulse_len  <= '0;
            still_len  <= '0;
            prev_addr  <= '0;
            prev_data  <= '0;
            prev_drive <= 1'b0;
        end else begin
            pulse_len <= pulse ? ((pulse_len == '1) ? pulse_len : pulse_len + 1'b1) : '0;
            if (mem_addr_o != prev_addr || mem_data_o != prev_data || mem_drive_o != prev_drive)
                still_len <= CW'(1);
            else if (still_len != '1)
                still_len <= still_len + 1'b1;
            prev_addr  <= mem_addr_o;
            prev_data  <= mem_data_o;
            prev_drive <= mem_drive_o;
        end
    end

    // R3: every program pulse lasts exactly PULSE_CYC cycles
    assert_pulse_len_R3: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse) |-> (pulse_len == CW'(PULSE_CYC)));

    // R3: a pulse happens only with elevated supplies and data driven
    assert_pulse_supply_R3: assert property (@(posedge clk) disable iff (rst)
        pulse |-> (vpp_hi_o && vcc_hi_o && mem_drive_o));

    // R4: address and data settle before the pulse begins
    assert_setup_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(pulse) |-> (still_len >= CW'(SETUP_CYC)));

    // R5: interactive read-back releases the bus under elevated supplies
    assert_verify_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_ce_n_o && !mem_oe_n_o) |-> (!mem_drive_o && vpp_hi_o && vcc_hi_o));

    // R7: closing reads run at nominal supply with the bus released
    assert_final_nominal_R7: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n_o && !mem_oe_n_o) |-> (!vpp_hi_o && !vcc_hi_o && !mem_drive_o));
endmodule

// File: tb/burn_sequencer_bench.sv
`timescale 1ns/1ps
module burn_sequencer_bench;
    localparam int AW     = 4;
    localparam int DW     = 8;
    localparam int PULSE  = 20;
    localparam int SETUP  = 3;
    localparam int HOLD   = 3;
    localparam int SAMPLE = 4;
    localparam int MAXT   = 10;
    localparam int NADDR  = 1 << AW;

    typedef struct packed {
        logic [3:0] base_need;
        logic [3:0] odd_addr;
        logic [3:0] odd_need;
        logic       weak_en;
        logic [3:0] weak_addr;
        logic       exp_pass;
        logic [3:0] exp_faddr;
        logic       poke;
    } vec_t;

    // base need, odd address/need, weak byte at nominal supply, expected verdict
    localparam vec_t VECS [6] = '{
        '{4'd1, 4'd0,  4'd1,  1'b0, 4'd0, 1'b1, 4'd0, 1'b0},
        '{4'd1, 4'd5,  4'd4,  1'b0, 4'd0, 1'b1, 4'd0, 1'b1},
        '{4'd2, 4'd15, 4'd11, 1'b0, 4'd0, 1'b1, 4'd0, 1'b0},
        '{4'd1, 4'd7,  4'd12, 1'b0, 4'd0, 1'b0, 4'd7, 1'b0},
        '{4'd1, 4'd0,  4'd1,  1'b1, 4'd9, 1'b0, 4'd9, 1'b0},
        '{4'd3, 4'd3,  4'd12, 1'b1, 4'd2, 1'b0, 4'd3, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] img_addr, mem_addr, fail_addr;
    logic [DW-1:0] img_data, mem_dout, mem_din;
    logic          drive, ce_n, oe_n, vpp_hi, vcc_hi, done, pass, fail;

    int   checks = 0;
    int   failures = 0;
    vec_t cfg = '0;
    logic mon_clr = 1'b1;

    always #10 clk = ~clk;

    function automatic logic [7:0] img_of(logic [3:0] a);
        return {a, a} ^ 8'h5A;
    endfunction

    function automatic int need_of(vec_t v, int a);
        return (a == int'(v.odd_addr)) ? int'(v.odd_need) : int'(v.base_need);
    endfunction

    function automatic int retry_fail(vec_t v);
        for (int a = 0; a < NADDR; a++)
            if (need_of(v, a) > MAXT + 1) return a;
        return -1;
    endfunction

    function automatic int exp_pulses(vec_t v, int a);
        int n;
        int rf;
        n  = need_of(v, a);
        rf = retry_fail(v);
        if (rf >= 0 && a > rf) return 1;
        return (n > MAXT + 1) ? MAXT + 1 : n;
    endfunction

    burn_sequencer #(
        .AW(AW), .DW(DW), .PULSE_CYC(PULSE), .SETUP_CYC(SETUP),
        .HOLD_CYC(HOLD), .SAMPLE_CYC(SAMPLE), .MAX_TRIES(MAXT)
    ) u_burn_sequencer (
        .clk(clk), .rst(rst), .start_i(start),
        .img_addr_o(img_addr), .img_data_i(img_data),
        .mem_addr_o(mem_addr), .mem_data_o(mem_dout), .mem_drive_o(drive),
        .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .vpp_hi_o(vpp_hi), .vcc_hi_o(vcc_hi),
        .mem_data_i(mem_din), .done_o(done), .pass_o(pass), .fail_o(fail),
        .fail_addr_o(fail_addr)
    );

    // Target memory model and port monitor, both sampled on the falling edge.
    logic [7:0] cells [NADDR];
    int         hits [NADDR];
    int         pulses [NADDR];
    int  stable_cnt, plen, since_rise, rd_cnt, sup_cnt, fin_visits;
    int  v_setup, v_hold, v_width, v_pulse, v_read, v_fin, v_sup;
    logic prev_pulse, prev_rd, prev_ce, prev_doe;
    logic [AW-1:0] prev_addr;
    logic [DW-1:0] prev_dout;
    logic pulse_now, rd_now, chg;

    assign img_data  = img_of(img_addr);
    assign pulse_now = !ce_n && oe_n;
    assign rd_now    = !oe_n;
    assign chg       = (mem_addr != prev_addr) || (mem_dout != prev_dout) || (drive != prev_doe);
    assign mem_din   = oe_n ? 8'hFF :
                       (cells[mem_addr] ^ ((cfg.weak_en && mem_addr == cfg.weak_addr && !vcc_hi) ? 8'h01 : 8'h00));

    always @(negedge clk) begin
        if (mon_clr) begin
            for (int a = 0; a < NADDR; a++) begin
                cells[a] = 8'hFF; hits[a] = 0; pulses[a] = 0;
            end
            stable_cnt = 0; plen = 0; since_rise = 0; rd_cnt = 0; sup_cnt = 0; fin_visits = 0;
            v_setup = 0; v_hold = 0; v_width = 0; v_pulse = 0; v_read = 0; v_fin = 0; v_sup = 0;
        end else begin
            stable_cnt = chg ? 0 : stable_cnt + 1;
            sup_cnt    = (vpp_hi && vcc_hi) ? sup_cnt + 1 : 0;
            if (since_rise > 0) begin
                if (chg) begin
                    if (since_rise < HOLD) v_hold++;
                    since_rise = 0;
                end else since_rise++;
            end
            if (pulse_now && !prev_pulse) begin
                pulses[mem_addr]++;
                if (stable_cnt < SETUP) v_setup++;
                if (sup_cnt < SETUP) v_sup++;
                if (vpp_hi) begin
                    hits[mem_addr]++;
                    if (hits[mem_addr] >= need_of(cfg, int'(mem_addr)))
                        cells[mem_addr] = cells[mem_addr] & mem_dout;
                end
                plen = 1;
            end else if (pulse_now) plen++;
            if (!pulse_now && prev_pulse) begin
                if (plen != PULSE) v_width++;
                since_rise = 1;
            end
            if (pulse_now && !(vpp_hi && vcc_hi && drive && mem_dout == img_of(mem_addr))) v_pulse++;
            if (prev_rd && (!rd_now || mem_addr != prev_addr) && rd_cnt < SAMPLE) v_read++;
            rd_cnt = rd_now ? ((prev_rd && mem_addr == prev_addr) ? rd_cnt + 1 : 1) : 0;
            if (rd_now && ce_n && (drive || !vpp_hi || !vcc_hi)) v_read++;
            if (rd_now && !ce_n && (drive || vpp_hi || vcc_hi)) v_fin++;
            if (rd_now && !ce_n && (!(prev_rd && !prev_ce) || mem_addr != prev_addr)) fin_visits++;
        end
        prev_pulse = pulse_now; prev_rd = rd_now; prev_ce = ce_n;
        prev_addr = mem_addr; prev_dout = mem_dout; prev_doe = drive;
    end

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_park(string what);
        check(ce_n && oe_n && !vpp_hi && !vcc_hi && !drive && !done && !pass && !fail,
              "R1", what, {ce_n, oe_n, vpp_hi, vcc_hi, drive, done, pass, fail}, 8'b11000000);
    endtask

    task automatic run_vec(vec_t v, int idx);
        int waited;
        int bad;
        int first;
        int exp_fin;
        @(negedge clk);
        cfg = v; mon_clr = 1'b1;
        @(negedge clk);
        @(negedge clk);
        mon_clr = 1'b0; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        waited = 0;
        while (!done && waited < 20000) begin
            @(negedge clk);
            waited++;
            if (v.poke && waited == 300) start = 1'b1;   // R9: ignored mid-run
            else start = 1'b0;
        end
        start = 1'b0;
        check(done, "R8", $sformatf("vec%0d finished before watchdog", idx), waited, 20000);
        check(done && (pass == v.exp_pass) && (fail == !v.exp_pass), "R8",
              $sformatf("vec%0d verdict pass/fail", idx), {pass, fail}, {v.exp_pass, !v.exp_pass});
        if (!v.exp_pass)
            check(fail_addr == v.exp_faddr, v.weak_en && retry_fail(v) < 0 ? "R7" : "R6",
                  $sformatf("vec%0d fail address", idx), fail_addr, v.exp_faddr);
        bad = 0; first = -1;
        for (int a = 0; a < NADDR; a++)
            if (pulses[a] != exp_pulses(v, a)) begin
                bad++;
                if (first < 0) first = a;
            end
        check(bad == 0, "R6", $sformatf("vec%0d pulses per address (first bad addr %0d)", idx, first),
              first >= 0 ? pulses[first] : 0, first >= 0 ? exp_pulses(v, first) : 0);
        check(v_width == 0 && v_pulse == 0, "R3", $sformatf("vec%0d pulse shape violations", idx),
              v_width + v_pulse, 0);
        check(v_setup == 0 && v_hold == 0, "R4", $sformatf("vec%0d setup/hold violations", idx),
              v_setup + v_hold, 0);
        check(v_sup == 0, "R2", $sformatf("vec%0d supply lead violations", idx), v_sup, 0);
        check(v_read == 0, "R5", $sformatf("vec%0d read window violations", idx), v_read, 0);
        if (retry_fail(v) >= 0) exp_fin = 0;
        else if (!v.exp_pass) exp_fin = int'(v.exp_faddr) + 1;
        else exp_fin = NADDR;
        check(fin_visits == exp_fin && v_fin == 0, "R7", $sformatf("vec%0d nominal reads", idx),
              fin_visits, exp_fin);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        check_park("outputs during reset");
        rst = 1'b0;
        @(negedge clk);
        check_park("outputs after reset");

        for (int i = 0; i < 6; i++) run_vec(VECS[i], i);

        // R9: a new start after done clears the verdict within one cycle
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(!done && !pass && !fail && vpp_hi && vcc_hi, "R9", "restart clears verdict",
              {done, pass, fail, vpp_hi}, 4'b0001);

        // R1: reset in the middle of a run parks the outputs
        repeat (100) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check_park("reset mid-run");
        rst = 1'b0;
        @(negedge clk);
        check_park("idle after mid-run reset");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule